// File: doc/BRIEF.md
# Bicubic tap weight generator

This block turns one two-point blend weight into the four signed coefficients of a 4-tap resampling filter. The taps sit at source positions -1, 0, +1 and +2 around the sample point. A client supplies a weight on a 0..512 scale, where 512 selects the pixel at position 0 and 0 selects the pixel at position +1. It also supplies a sharpness code and pulses `start_i`. Some cycles later the block raises `done_o` for one cycle, and at that point the four coefficients are on its outputs. The coefficients stay there until the next run finishes.

The sharpness code picks the kernel:
- Code 0 gives nearest-neighbour.
- Code 1 gives plain linear blending.
- Codes 2 and above give cubic convolution. The kernel parameter is a = -code/8, so code 2 gives -0.25, code 8 gives -1.0 and code 32 gives -4.0.

The cubic path works in signed fixed point with 16 fractional bits. It shares one multiplier across a squaring step and a cubing step for each tap, then evaluates the kernel, rounds and saturates.

A state machine sequences the work:
- IDLE goes to LINEAR on an accepted start with code 0 or 1, and to SQUARE on an accepted start with code 2 or more.
- LINEAR goes to DONE.
- For each tap in turn, SQUARE goes to CUBE, CUBE goes to KERNEL and KERNEL goes to STORE.
- STORE goes back to SQUARE for the next tap, or to DONE after the fourth tap.
- DONE always returns to IDLE.

Top module: `bicubic_tap_gen`

## Requirements
- R1: A weight input above 512 is treated as 512 before any other step.
- R2: With sharpness 0, the clamped weight is snapped: values of 256 or more become 512 and smaller values become 0. The linear rule of R3 then applies.
- R3: With sharpness 0 or 1, the taps are, in order -1, 0, +1, +2: 0, w, 512-w, 0.
- R4: With sharpness s of 2 or more, the kernel parameter is a = -s/8. For x ≤ 1 the kernel is k(x) = (a+2)x³ - (a+3)x² + 1. For 1 < x ≤ 2 it is a(x³ - 5x² + 8x - 4). Beyond 2 it is 0. Every product is formed in 16-fractional-bit fixed point and scaled back with truncation toward zero, including x² and x³.
- R5: With v = 512 - w, the four tap distances for taps -1, 0, +1, +2 are (512+v)/512, v/512, (512-v)/512 and (1024-v)/512.
- R6: Each cubic tap is (512·k + 0.5) in fixed point, reduced to an integer by truncation toward zero, then saturated to -1024..1023.
- R7: `done_o` is high for exactly one cycle. It rises 1 clock edge after the edge that accepts `start_i` when sharpness is below 2, and 16 edges after it otherwise.
- R8: `start_i` is accepted only in IDLE. A strobe during a computation, including the cycle in which `done_o` is high, has no effect on the results or on the timing of `done_o`.
- R9: After reset `done_o` is 0 and all taps are 0. The taps change only on the edge at which `done_o` rises and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled in IDLE |
| weight_i | input | 10 | Blend weight, 0..512 meaningful, larger values clamp |
| sharp_i | input | 6 | Sharpness code 0..32 |
| done_o | output | 1 | One-cycle completion pulse |
| tap_m1_o | output | 11 | Signed coefficient for source offset -1 |
| tap_z_o | output | 11 | Signed coefficient for source offset 0 |
| tap_p1_o | output | 11 | Signed coefficient for source offset +1 |
| tap_p2_o | output | 11 | Signed coefficient for source offset +2 |

## Verification
Two functions can meet in one cycle: the completion pulse and the acceptance of a new start strobe. The bench provokes this by raising `start_i` with fresh operands in exactly the cycle where `done_o` is high. It also raises a second strobe in the middle of a cubic run. In both cases the behavioural reference model, compared on every clock, expects the strobe to be dropped. The bench then judges that no extra pulse appears and that the taps keep the first run's values. Accuracy is covered by a sweep of every sharpness code over many weights, and by full weight sweeps at three codes. Those sweeps include weights above 512 and the snap threshold at 256.

// File: rtl/tapgen_pkg.sv
package tapgen_pkg;

    localparam int FX_FRAC = 16;
    localparam int FX_W    = 48;

    typedef logic signed [FX_W-1:0] fx_t;

    localparam fx_t FX_ONE = fx_t'(1) <<< FX_FRAC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LIN,
        ST_SQR,
        ST_CUBE,
        ST_KERN,
        ST_STORE,
        ST_DONE
    } tg_state_e;

endpackage

// File: rtl/tg_fx_mul.sv
// Fixed-point multiply: full product, then scale back by 2^-FRAC,
// rounding toward zero like a signed integer division.
module tg_fx_mul #(
    parameter int W    = 48,
    parameter int FRAC = 16
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] prod_o
);
    localparam int PW = 2 * W;
    localparam logic signed [PW-1:0] NEG_BIAS = (PW'(1) << FRAC) - PW'(1);

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] biased;

    always_comb begin
        full   = PW'(op_a) * PW'(op_b);
        biased = full[PW-1] ? full + NEG_BIAS : full;
        prod_o = W'(biased >>> FRAC);
    end
endmodule

// File: rtl/tg_cubic_kernel.sv
// Piecewise cubic convolution kernel, evaluated from x, x^2, x^3.
module tg_cubic_kernel
    import tapgen_pkg::*;
(
    input  fx_t a_i,
    input  fx_t x_i,
    input  fx_t x2_i,
    input  fx_t x3_i,
    output fx_t k_o
);
    localparam fx_t TWO   = FX_ONE <<< 1;
    localparam fx_t THREE = FX_ONE + TWO;
    localparam fx_t FOUR  = FX_ONE <<< 2;

    fx_t coef_cube;
    fx_t coef_sq;
    fx_t outer_poly;
    fx_t inner_p3;
    fx_t inner_p2;
    fx_t outer_p;

    assign coef_cube  = a_i + TWO;
    assign coef_sq    = a_i + THREE;
    assign outer_poly = x3_i - ((x2_i <<< 2) + x2_i) + (x_i <<< 3) - FOUR;

    tg_fx_mul #(.W(FX_W), .FRAC(FX_FRAC)) u_mul_cube (
        .op_a   (coef_cube),
        .op_b   (x3_i),
        .prod_o (inner_p3)
    );

    tg_fx_mul #(.W(FX_W), .FRAC(FX_FRAC)) u_mul_sq (
        .op_a   (coef_sq),
        .op_b   (x2_i),
        .prod_o (inner_p2)
    );

    tg_fx_mul #(.W(FX_W), .FRAC(FX_FRAC)) u_mul_outer (
        .op_a   (a_i),
        .op_b   (outer_poly),
        .prod_o (outer_p)
    );

    always_comb begin
        if (x_i <= FX_ONE) begin
            k_o = inner_p3 - inner_p2 + FX_ONE;
        end else if (x_i <= TWO) begin
            k_o = outer_p;
        end else begin
            k_o = '0;
        end
    end
endmodule

// File: rtl/tg_tap_shaper.sv
// Scale a kernel value to tap units, add one half, truncate toward zero
// and saturate to the signed tap width.
module tg_tap_shaper
    import tapgen_pkg::*;
#(
    parameter int TAP_W      = 11,
    parameter int SCALE_LOG2 = 9
) (
    input  fx_t                     k_i,
    output logic signed [TAP_W-1:0] tap_o
);
    localparam fx_t HALF     = FX_ONE >>> 1;
    localparam fx_t NEG_BIAS = FX_ONE - fx_t'(1);
    localparam fx_t TAP_MAX  = fx_t'((1 << (TAP_W - 1)) - 1);
    localparam fx_t TAP_MIN  = -fx_t'(1 << (TAP_W - 1));

    fx_t scaled;
    fx_t biased;
    fx_t whole;

    always_comb begin
        scaled = (k_i <<< SCALE_LOG2) + HALF;
        biased = scaled[FX_W-1] ? scaled + NEG_BIAS : scaled;
        whole  = biased >>> FX_FRAC;
        if (whole > TAP_MAX) begin
            tap_o = TAP_MAX[TAP_W-1:0];
        end else if (whole < TAP_MIN) begin
            tap_o = TAP_MIN[TAP_W-1:0];
        end else begin
            tap_o = whole[TAP_W-1:0];
        end
    end
endmodule

// File: rtl/bicubic_tap_gen.sv
module bicubic_tap_gen
    import tapgen_pkg::*;
#(
    parameter int WT_W        = 10,
    parameter int SHARP_W     = 6,
    parameter int TAP_W       = 11,
    parameter int UNITY_LOG2  = 9,
    parameter int SHARP_SHIFT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [WT_W-1:0]          weight_i,
    input  logic [SHARP_W-1:0]       sharp_i,
    output logic                     done_o,
    output logic signed [TAP_W-1:0]  tap_m1_o,
    output logic signed [TAP_W-1:0]  tap_z_o,
    output logic signed [TAP_W-1:0]  tap_p1_o,
    output logic signed [TAP_W-1:0]  tap_p2_o
);
    localparam int                 DW          = UNITY_LOG2 + 2;
    localparam int                 NTAPS       = 4;
    localparam int                 UNITY_I     = 1 << UNITY_LOG2;
    localparam logic [WT_W-1:0]    UNITY_W     = WT_W'(UNITY_I);
    localparam logic [WT_W-1:0]    HALF_W      = WT_W'(UNITY_I / 2);
    localparam logic [DW-1:0]      UNITY_N     = DW'(UNITY_I);
    localparam logic [SHARP_W-1:0] SHARP_CUBIC = SHARP_W'(2);
    localparam logic [1:0]         LAST_IDX    = 2'(NTAPS - 1);

    tg_state_e state_q;
    tg_state_e state_d;

    logic [WT_W-1:0]         wt_clamp;
    logic [WT_W-1:0]         wt_eff;
    logic [DW-1:0]           wp_eff;
    fx_t                     a_eff;
    logic                    accept;

    logic [WT_W-1:0]         wt_q;
    logic [DW-1:0]           wp_q;
    logic [SHARP_W-1:0]      sharp_q;
    logic [1:0]              idx_q;
    fx_t                     a_q;
    fx_t                     x_q;
    fx_t                     x2_q;
    fx_t                     x3_q;
    fx_t                     k_q;

    fx_t                     mul_b;
    fx_t                     mul_y;
    fx_t                     kern_y;
    logic signed [TAP_W-1:0] tap_y;

    logic signed [TAP_W-1:0] stash_q [NTAPS-1];
    logic signed [TAP_W-1:0] res_q   [NTAPS];

    // Distance of tap i from the sample point, in fixed point.
    function automatic fx_t dist_of(input logic [1:0] i, input logic [DW-1:0] wp);
        logic [DW-1:0] n;
        case (i)
            2'd0:    n = UNITY_N + wp;
            2'd1:    n = wp;
            2'd2:    n = UNITY_N - wp;
            default: n = (UNITY_N << 1) - wp;
        endcase
        return fx_t'(n) <<< (FX_FRAC - UNITY_LOG2);
    endfunction

    // Input conditioning: clamp, optional snap, complement, kernel parameter.
    always_comb begin
        wt_clamp = (weight_i > UNITY_W) ? UNITY_W : weight_i;
        if (sharp_i == '0) begin
            wt_eff = (wt_clamp >= HALF_W) ? UNITY_W : '0;
        end else begin
            wt_eff = wt_clamp;
        end
        wp_eff = UNITY_N - DW'(wt_eff);
        a_eff  = -(fx_t'(sharp_i) <<< (FX_FRAC - SHARP_SHIFT));
        accept = (state_q == ST_IDLE) && start_i;
    end

    // One multiplier serves both the square and the cube of x.
    assign mul_b = (state_q == ST_SQR) ? x_q : x2_q;

    tg_fx_mul #(.W(FX_W), .FRAC(FX_FRAC)) u_pow (
        .op_a   (x_q),
        .op_b   (mul_b),
        .prod_o (mul_y)
    );

    tg_cubic_kernel u_kern (
        .a_i  (a_q),
        .x_i  (x_q),
        .x2_i (x2_q),
        .x3_i (x3_q),
        .k_o  (kern_y)
    );

    tg_tap_shaper #(.TAP_W(TAP_W), .SCALE_LOG2(UNITY_LOG2)) u_shape (
        .k_i   (k_q),
        .tap_o (tap_y)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (sharp_i < SHARP_CUBIC) ? ST_LIN : ST_SQR;
                end
            end
            ST_LIN:   state_d = ST_DONE;
            ST_SQR:   state_d = ST_CUBE;
            ST_CUBE:  state_d = ST_KERN;
            ST_KERN:  state_d = ST_STORE;
            ST_STORE: state_d = (idx_q == LAST_IDX) ? ST_DONE : ST_SQR;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q    <= '0;
            wp_q    <= '0;
            sharp_q <= '0;
            idx_q   <= '0;
            a_q     <= '0;
            x_q     <= '0;
            x2_q    <= '0;
            x3_q    <= '0;
            k_q     <= '0;
            for (int i = 0; i < NTAPS - 1; i++) stash_q[i] <= '0;
            for (int i = 0; i < NTAPS; i++)     res_q[i]   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        wt_q    <= wt_eff;
                        wp_q    <= wp_eff;
                        sharp_q <= sharp_i;
                        a_q     <= a_eff;
                        idx_q   <= '0;
                        x_q     <= dist_of(2'd0, wp_eff);
                    end
                end
                ST_LIN: begin
                    res_q[0] <= '0;
                    res_q[1] <= TAP_W'(wt_q);
                    res_q[2] <= TAP_W'(UNITY_W - wt_q);
                    res_q[3] <= '0;
                end
                ST_SQR:  x2_q <= mul_y;
                ST_CUBE: x3_q <= mul_y;
                ST_KERN: k_q  <= kern_y;
                ST_STORE: begin
                    if (idx_q == LAST_IDX) begin
                        for (int i = 0; i < NTAPS - 1; i++) res_q[i] <= stash_q[i];
                        res_q[NTAPS-1] <= tap_y;
                    end else begin
                        for (int i = 0; i < NTAPS - 2; i++) stash_q[i] <= stash_q[i+1];
                        stash_q[NTAPS-2] <= tap_y;
                        idx_q <= idx_q + 2'd1;
                        x_q   <= dist_of(idx_q + 2'd1, wp_q);
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        done_o   = (state_q == ST_DONE);
        tap_m1_o = res_q[0];
        tap_z_o  = res_q[1];
        tap_p1_o = res_q[2];
        tap_p2_o = res_q[3];
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_drops_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    a_r1_weight_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (wt_q <= UNITY_W));

    a_r3_linear_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sharp_q < SHARP_CUBIC) |->
        (tap_m1_o == '0 && tap_p2_o == '0 && (int'(tap_z_o) + int'(tap_p1_o)) == UNITY_I));

    a_r2_snapped: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sharp_q == '0) |-> (int'(tap_z_o) == 0 || int'(tap_z_o) == UNITY_I));

    for (genvar g = 0; g < NTAPS; g++) begin : g_hold
        a_r9_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(res_q[g]) |-> done_o);
    end

endmodule

// File: tb/bicubic_tap_gen_test.sv
`timescale 1ns/1ps
module bicubic_tap_gen_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n;
    logic               start;
    logic [9:0]         w_in;
    logic [5:0]         s_in;
    logic               done;
    logic signed [10:0] t0, t1, t2, t3;

    bicubic_tap_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .weight_i (w_in),
        .sharp_i  (s_in),
        .done_o   (done),
        .tap_m1_o (t0),
        .tap_z_o  (t1),
        .tap_p1_o (t2),
        .tap_p2_o (t3)
    );

    int    checks = 0;
    int    fails  = 0;
    int    ncyc   = 0;
    int    m_cnt  = 0;
    bit    m_done = 1'b0;
    bit    busy_phase = 1'b0;
    int    e [4];
    int    p [4];
    string e_tag = "R9";
    string p_tag = "R9";

    // ---------------- behavioural reference ----------------
    function automatic longint fmul(longint a, longint b);
        return (a * b) / 65536;
    endfunction

    // R4 kernel
    function automatic longint kern(longint fa, longint fx);
        longint x2, x3;
        x2 = fmul(fx, fx);
        x3 = fmul(fx, x2);
        if (fx <= 65536)       return fmul(fa + 131072, x3) - fmul(fa + 196608, x2) + 65536;
        else if (fx <= 131072) return fmul(fa, x3 - 5 * x2 + 8 * fx - 262144);
        else                   return 0;
    endfunction

    function automatic string tag_for(int w, int s);
        if (busy_phase) return "R8";
        if (w > 512)    return "R1";
        if (s == 0)     return "R2";
        if (s == 1)     return "R3";
        return "R4 R5 R6";
    endfunction

    task automatic ref_calc(input int w, input int s);
        int wc, vp;
        int n [4];
        longint v;
        wc = (w > 512) ? 512 : w;                      // R1
        if (s == 0) wc = (wc >= 256) ? 512 : 0;         // R2
        if (s < 2) begin                                // R3
            p[0] = 0; p[1] = wc; p[2] = 512 - wc; p[3] = 0;
        end else begin
            vp   = 512 - wc;                            // R5
            n[0] = 512 + vp; n[1] = vp; n[2] = 512 - vp; n[3] = 1024 - vp;
            for (int i = 0; i < 4; i++) begin
                v = (32768 + 512 * kern(-8192 * longint'(s), longint'(n[i]) * 65536 / 512)) / 65536; // R6
                if (v > 1023)  v = 1023;
                if (v < -1024) v = -1024;
                p[i] = int'(v);
            end
        end
    endtask

    // Cycle model: R7 latency, R8 busy drop, R9 hold.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt  = 0;
            m_done = 1'b0;
            for (int i = 0; i < 4; i++) e[i] = 0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_done = 1'b1;
                for (int i = 0; i < 4; i++) e[i] = p[i];
                e_tag = p_tag;
            end
        end else if (m_done) begin
            m_done = 1'b0;
        end else if (start) begin
            ref_calc(int'(w_in), int'(s_in));
            p_tag = tag_for(int'(w_in), int'(s_in));
            m_cnt = (s_in < 6'd2) ? 1 : 16;
        end
    end

    // Comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        ncyc++;
        if (ncyc > 2) begin
            checks++;
            if (done !== m_done) begin
                fails++;
                $display("FAIL %s done: actual=%0b expected=%0b", busy_phase ? "R8" : "R7", done, m_done);
            end
            checks++;
            if ($isunknown({t0, t1, t2, t3}) || int'(t0) != e[0] || int'(t1) != e[1] ||
                int'(t2) != e[2] || int'(t3) != e[3]) begin
                fails++;
                $display("FAIL %s taps (w=%0d s=%0d): actual=%0d %0d %0d %0d expected=%0d %0d %0d %0d",
                         m_done ? e_tag : "R9", w_in, s_in, t0, t1, t2, t3, e[0], e[1], e[2], e[3]);
            end
        end
    end

    task automatic run(input int w, input int s);
        @(negedge clk);
        w_in  = 10'(w);
        s_in  = 6'(s);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt != 0 || m_done) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual=busy expected=idle");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        w_in  = '0;
        s_in  = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4: every sharpness code over a coarse weight grid and corners
        for (int s = 0; s <= 32; s++) begin
            for (int w = 0; w <= 512; w += 16) run(w, s);
            run(1, s); run(255, s); run(256, s); run(257, s);
            run(511, s);
            run(513, s); run(1023, s);                  // R1
        end
        // R1 R5 R6: full weight sweep at the default code
        for (int w = 0; w < 1024; w++) run(w, 8);
        // R4 R6: extremes of the cubic parameter
        for (int w = 0; w <= 512; w++) run(w, 2);
        for (int w = 0; w <= 512; w++) run(w, 32);

        // R8: strobe mid-computation and strobe in the done cycle are dropped
        busy_phase = 1'b1;
        @(negedge clk);
        w_in = 10'd300; s_in = 6'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        w_in = 10'd0; s_in = 6'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        w_in = 10'd1023; s_in = 6'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        run(128, 1);
        busy_phase = 1'b0;
        run(384, 12);

        finish_run();
    end

endmodule